// File: doc/BRIEF.md
# Opmask Register Move Unit

This unit decodes and executes the moves that carry an opmask value between an eight-entry bank of 64-bit mask registers, a general-purpose register (GPR) and memory. Each instruction is presented for one clock cycle with the following inputs:

- its opcode byte;
- a two-bit prefix selector;
- the W bit;
- the ModRM byte;
- a flag that says whether the core runs in 64-bit mode.

The GPR read value and the memory read value arrive on plain data inputs. Address generation and the GPR file sit outside the unit.

The result leaves the unit on one of three write ports during that same cycle: mask bank, GPR or memory. A mask bank write commits at the rising edge that ends the cycle. The operand width (8, 16, 32 or 64 bits) comes from the prefix and W. Values bound for a mask register or a GPR are zero-extended. A store writes only the bytes of the selected width. Any illegal encoding raises `inval` and suppresses every write.

Top module: `opmask_move_unit`

## Requirements
- R1: After reset, all eight mask registers read as zero.
- R2: Opcode 0x90 with ModRM[7:6]=11 copies mask register rm into mask register reg. The copy is truncated to the width and zero-extended to 64 bits. For opcodes 0x90 and 0x91 the width depends on prefix and W: prefix 0 gives 16 bits (W=0) or 64 bits (W=1); prefix 1 gives 8 bits (W=0) or 32 bits (W=1).
- R3: Opcode 0x90 with ModRM[7:6]≠11 loads `mem_rdata` into mask register reg, truncated to the width and zero-extended.
- R4: Opcode 0x91 with ModRM[7:6]≠11 stores mask register reg on `mwr_data`, truncated to the width with the upper bits zero. `mwr_be` enables exactly the low 1, 2, 4 or 8 bytes.
- R5: Opcode 0x91 with ModRM[7:6]=11 raises `inval` and performs no write.
- R6: Opcode 0x92 with ModRM[7:6]=11 writes `gpr_rdata`, truncated and zero-extended, into mask register reg. For opcodes 0x92 and 0x93 the width depends on prefix and W: prefix 0, W=0 gives 16 bits; prefix 1, W=0 gives 8 bits; prefix 2, W=0 gives 32 bits; prefix 2, W=1 gives 64 bits.
- R7: Opcode 0x93 with ModRM[7:6]=11 writes mask register rm, truncated and zero-extended, to GPR reg. `gwr_size64` equals `mode64`.
- R8: Opcodes 0x92 and 0x93 with ModRM[7:6]≠11 raise `inval` and perform no write.
- R9: Prefix 2 with W=1 on opcodes 0x92 and 0x93 raises `inval` when `mode64` is 0.
- R10: Each of the following raises `inval`, performs no write and leaves the bank unchanged: any other opcode, prefix 3, prefix 2 on opcodes 0x90 and 0x91, and W=1 with prefix 0 or 1 on opcodes 0x92 and 0x93.
- R11: A mask write commits at the clock edge, and a read in the next cycle returns the new value.
- R12: With `in_valid` low, no write enable and no `inval` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Opcode byte |
| pfx | input | 2 | Prefix: 0 none, 1 operand-size, 2 repne, 3 reserved |
| wbit | input | 1 | W bit |
| modrm | input | 8 | ModRM byte |
| mode64 | input | 1 | Core is in 64-bit mode |
| gpr_rdata | input | 64 | GPR source value |
| mem_rdata | input | 64 | Memory load value |
| gpr_ridx | output | 3 | GPR index to read (ModRM rm) |
| kwr_en | output | 1 | Mask register write enable |
| kwr_idx | output | 3 | Mask register write index |
| kwr_data | output | 64 | Mask register write value |
| gwr_en | output | 1 | GPR write enable |
| gwr_idx | output | 3 | GPR write index |
| gwr_data | output | 64 | GPR write value |
| gwr_size64 | output | 1 | GPR destination is 64 bits wide |
| mwr_en | output | 1 | Memory write enable |
| mwr_data | output | 64 | Memory write value |
| mwr_be | output | 8 | Memory byte enables |
| inval | output | 1 | Invalid encoding |

## Verification
Random instructions cover all four opcodes plus stray ones, and every combination of prefix, W, mode and ModRM. These runs tell the width rows apart, and they separate the register, memory and GPR operand paths. The data values have set bits across all 64 positions, so a wrong truncation or a missing zero extension shows up in the write data. Directed sequences read the bank straight after reset and read a register in the cycle after it is written, which exposes a late or missing commit. Illegal encodings are each followed by a read-back, which shows that the bank was left untouched.

// File: rtl/opmask_move_unit.sv
module opmask_move_unit #(
  parameter int NK = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [1:0]  pfx,
  input  logic        wbit,
  input  logic [7:0]  modrm,
  input  logic        mode64,
  input  logic [63:0] gpr_rdata,
  input  logic [63:0] mem_rdata,
  output logic [2:0]  gpr_ridx,
  output logic        kwr_en,
  output logic [2:0]  kwr_idx,
  output logic [63:0] kwr_data,
  output logic        gwr_en,
  output logic [2:0]  gwr_idx,
  output logic [63:0] gwr_data,
  output logic        gwr_size64,
  output logic        mwr_en,
  output logic [63:0] mwr_data,
  output logic [7:0]  mwr_be,
  output logic        inval
);
  localparam int IW = $clog2(NK);

  logic [63:0] kbank [NK];

  wire          is_reg = modrm[7:6] == 2'b11;
  wire [IW-1:0] r_reg  = modrm[3+:IW];
  wire [IW-1:0] r_rm   = modrm[0+:IW];
  wire          op90   = opcode == 8'h90;
  wire          op91   = opcode == 8'h91;
  wire          op92   = opcode == 8'h92;
  wire          op93   = opcode == 8'h93;

  logic [1:0]  sz;
  logic        legal;
  logic [63:0] wmask;

  always_comb begin
    sz    = 2'd0;
    legal = 1'b0;
    if (op90 || op91) begin
      case ({pfx, wbit})
        3'b000:  begin sz = 2'd1; legal = 1'b1; end
        3'b001:  begin sz = 2'd3; legal = 1'b1; end
        3'b010:  begin sz = 2'd0; legal = 1'b1; end
        3'b011:  begin sz = 2'd2; legal = 1'b1; end
        default: legal = 1'b0;
      endcase
      if (op91 && is_reg) legal = 1'b0;
    end else if (op92 || op93) begin
      case ({pfx, wbit})
        3'b000:  begin sz = 2'd1; legal = 1'b1; end
        3'b010:  begin sz = 2'd0; legal = 1'b1; end
        3'b100:  begin sz = 2'd2; legal = 1'b1; end
        3'b101:  begin sz = 2'd3; legal = mode64; end
        default: legal = 1'b0;
      endcase
      if (!is_reg) legal = 1'b0;
    end
  end

  always_comb begin
    case (sz)
      2'd0:    begin wmask = 64'h0000_0000_0000_00ff; mwr_be = 8'h01; end
      2'd1:    begin wmask = 64'h0000_0000_0000_ffff; mwr_be = 8'h03; end
      2'd2:    begin wmask = 64'h0000_0000_ffff_ffff; mwr_be = 8'h0f; end
      default: begin wmask = 64'hffff_ffff_ffff_ffff; mwr_be = 8'hff; end
    endcase
  end

  wire go = in_valid && legal;

  assign inval      = in_valid && !legal;
  assign gpr_ridx   = modrm[2:0];
  assign kwr_en     = go && (op90 || op92);
  assign kwr_idx    = modrm[5:3];
  assign kwr_data   = (op92 ? gpr_rdata : (is_reg ? kbank[r_rm] : mem_rdata)) & wmask;
  assign gwr_en     = go && op93;
  assign gwr_idx    = modrm[5:3];
  assign gwr_data   = kbank[r_rm] & wmask;
  assign gwr_size64 = mode64;
  assign mwr_en     = go && op91;
  assign mwr_data   = kbank[r_reg] & wmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NK; i++) kbank[i] <= '0;
    end else if (kwr_en) begin
      kbank[r_reg] <= kwr_data;
    end
  end

  p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kwr_en, gwr_en, mwr_en}));
  p_inval_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> !(kwr_en || gwr_en || mwr_en));
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !(inval || kwr_en || gwr_en || mwr_en));
  p_be_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_en |-> (mwr_be == 8'h01 || mwr_be == 8'h03 || mwr_be == 8'h0f || mwr_be == 8'hff));
  p_store_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_en && !mwr_be[7] |-> mwr_data[63:32] == 32'd0);
  p_narrow_gpr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gwr_en && !mode64 |-> gwr_data[63:32] == 32'd0);
  p_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    kwr_en |=> kbank[$past(r_reg)] == $past(kwr_data));
endmodule

// File: tb/opmask_move_unit_test.sv
module opmask_move_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [7:0]  opcode = 0;
  logic [1:0]  pfx = 0;
  logic        wbit = 0;
  logic [7:0]  modrm = 0;
  logic        mode64 = 0;
  logic [63:0] gpr_rdata = 0, mem_rdata = 0;
  logic [2:0]  gpr_ridx, kwr_idx, gwr_idx;
  logic        kwr_en, gwr_en, gwr_size64, mwr_en, inval;
  logic [63:0] kwr_data, gwr_data, mwr_data;
  logic [7:0]  mwr_be;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] model [8];

  opmask_move_unit uut (.*);

  always #5 clk = ~clk;

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic run_one(input logic [7:0] op, input logic [1:0] pf, input logic w,
                         input logic [7:0] mr, input logic m64, input logic v,
                         input logic [63:0] gd, input logic [63:0] md, input string tag_in);
    int bits;
    bit ok;
    bit regf;
    logic [63:0] msk, src;
    logic e_k, e_g, e_m, e_inv;
    logic [63:0] e_kd, e_gd, e_md;
    logic [7:0] e_be;
    string tag;
    bit bad;
    bits = 0; ok = 0; regf = mr[7:6] == 2'b11; tag = tag_in;
    if (op == 8'h90 || op == 8'h91) begin
      if (pf == 0) begin ok = 1; bits = w ? 64 : 16; end
      else if (pf == 1) begin ok = 1; bits = w ? 32 : 8; end
      if (op == 8'h91 && regf) begin ok = 0; if (tag == "") tag = "R5"; end
    end else if (op == 8'h92 || op == 8'h93) begin
      if (pf == 0 && !w) begin ok = 1; bits = 16; end
      else if (pf == 1 && !w) begin ok = 1; bits = 8; end
      else if (pf == 2 && !w) begin ok = 1; bits = 32; end
      else if (pf == 2 && w) begin
        ok = m64; bits = 64;
        if (!m64 && tag == "") tag = "R9";
      end
      if (!regf) begin ok = 0; if (tag == "") tag = "R8"; end
    end
    if (!ok && tag == "") tag = "R10";
    if (!v && tag == "") tag = "R12";
    if (tag == "") begin
      case (op)
        8'h90: tag = regf ? "R2" : "R3";
        8'h91: tag = "R4";
        8'h92: tag = "R6";
        default: tag = "R7";
      endcase
    end
    msk = bits == 64 ? '1 : ((64'd1 << bits) - 64'd1);
    e_inv = v && !ok;
    e_k = v && ok && (op == 8'h90 || op == 8'h92);
    e_g = v && ok && op == 8'h93;
    e_m = v && ok && op == 8'h91;
    src = op == 8'h92 ? gd : (regf ? model[mr[2:0]] : md);
    e_kd = src & msk;
    e_gd = model[mr[2:0]] & msk;
    e_md = model[mr[5:3]] & msk;
    e_be = bits == 8 ? 8'h01 : bits == 16 ? 8'h03 : bits == 32 ? 8'h0f : 8'hff;

    in_valid = v; opcode = op; pfx = pf; wbit = w; modrm = mr; mode64 = m64;
    gpr_rdata = gd; mem_rdata = md;
    #2;
    checks++;
    bad = (inval !== e_inv) || (kwr_en !== e_k) || (gwr_en !== e_g) || (mwr_en !== e_m);
    if (e_k && (kwr_idx !== mr[5:3] || kwr_data !== e_kd)) bad = 1;
    if (e_g && (gwr_idx !== mr[5:3] || gwr_data !== e_gd || gwr_size64 !== m64)) bad = 1;
    if (e_m && (mwr_data !== e_md || mwr_be !== e_be)) bad = 1;
    if (gpr_ridx !== mr[2:0]) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s op=%h pf=%0d w=%0d modrm=%h: actual inv=%b k=%b/%h g=%b/%h m=%b/%h/%h expected inv=%b k=%b/%h g=%b/%h m=%b/%h/%h",
               tag, op, pf, w, mr, inval, kwr_en, kwr_data, gwr_en, gwr_data, mwr_en, mwr_data, mwr_be,
               e_inv, e_k, e_kd, e_g, e_gd, e_m, e_md, e_be);
    end
    @(posedge clk);
    if (e_k) model[mr[5:3]] = e_kd;
    @(negedge clk);
  endtask

  task automatic read_k(input logic [2:0] i, input string tag);
    run_one(8'h93, 2'd2, 1'b1, {2'b11, 3'd0, i}, 1'b1, 1'b1, 64'd0, 64'd0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) read_k(3'(i), "R1");
    // R11: write with 0x92 (64-bit), read back at once
    run_one(8'h92, 2'd2, 1'b1, 8'hC8 | 8'h05, 1'b1, 1'b1, 64'hdead_beef_0123_4567, 0, "R6");
    read_k(3'd1, "R11");
    run_one(8'h90, 2'd1, 1'b0, 8'b11_010_001, 1'b1, 1'b1, 0, 0, "R2");
    read_k(3'd2, "R11");
    run_one(8'h90, 2'd0, 1'b1, 8'b01_011_100, 1'b0, 1'b1, 0, 64'hffff_0000_aaaa_5555, "R3");
    run_one(8'h91, 2'd1, 1'b1, 8'b10_011_000, 1'b0, 1'b1, 0, 0, "R4");
    run_one(8'h91, 2'd0, 1'b0, 8'b11_011_000, 1'b1, 1'b1, 0, 0, "R5");
    run_one(8'h93, 2'd2, 1'b0, 8'b00_000_011, 1'b1, 1'b1, 0, 0, "R8");
    run_one(8'h93, 2'd2, 1'b1, 8'b11_000_011, 1'b0, 1'b1, 0, 0, "R9");
    run_one(8'h92, 2'd2, 1'b1, 8'b11_011_000, 1'b0, 1'b1, 64'h1, 0, "R9");
    read_k(3'd3, "R10");
    run_one(8'h90, 2'd2, 1'b0, 8'b11_011_000, 1'b1, 1'b1, 0, 0, "R10");
    run_one(8'h92, 2'd0, 1'b1, 8'b11_011_000, 1'b1, 1'b1, 64'h77, 0, "R10");
    run_one(8'h94, 2'd0, 1'b0, 8'b11_011_000, 1'b1, 1'b1, 64'h77, 0, "R10");
    read_k(3'd3, "R10");
    run_one(8'h92, 2'd2, 1'b0, 8'b11_100_000, 1'b1, 1'b0, 64'h55, 0, "R12");
    read_k(3'd4, "R12");
    run_one(8'h93, 2'd0, 1'b0, 8'b11_000_001, 1'b0, 1'b1, 0, 0, "R7");
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] op;
      op = ($urandom() % 8 == 0) ? 8'($urandom()) : 8'h90 + 8'($urandom() % 4);
      run_one(op, 2'($urandom()), 1'($urandom()), 8'($urandom()), 1'($urandom()),
              ($urandom() % 10) != 0, rnd64(), rnd64(), "");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule